// File: doc/BRIEF.md
# Transmit Pause Scheduler with Idle Insertion

This block decides when a 64-bit XGMII-style transmitter may start its next frame. It weighs three sources of traffic: a pause time learned from a received pause frame, a local request to send an outgoing pause frame, and ordinary user data frames. While a received pause is in force, it drives IDLE control characters on the lane. It also reports the octet position within the idle stretch on every beat.

The received pause time is given in quanta. One quanta is 512 bit times, which is 64 octets or 8 beats of 8 octets. A new quanta value always replaces the one that is held, whether that pause is running or still waiting. A value of zero ends the pause. A pause that arrives while a frame is being sent waits until the frame's last beat has gone out.

After every frame, a separate gap timer holds off the next grant for a fixed number of beats. That timer runs at the same time as any pause. Frame building, CRC and the exact gap pattern belong to the surrounding data path.

Top module: `tx_pause_sched`

## Requirements
- R1: While reset is asserted, and on the first beat after it is released, both grants, `idle_force`, `idle_octet`, `idle_txd` and `idle_txc` are all zero.
- R2: On a free line, a `quanta_vld` pulse carrying a value Q greater than zero raises `idle_force` on the next beat. `idle_force` then stays high for exactly Q×8 consecutive beats.
- R3: While `idle_force` is high, every octet of `idle_txd` is 0x07 and every bit of `idle_txc` is 1. While it is low, both are zero.
- R4: `idle_octet` is 0 on the first idle beat of a pause and rises by 8 on each following idle beat. The first beat after a reload counts as a first idle beat.
- R5: No grant is issued while a received pause is held, whether it is running or queued. A request that is waiting is granted on the first beat after the pause ends.
- R6: A quanta that arrives while a frame is in flight does not raise `idle_force` before the frame's `frame_last` beat. The full Q×8 idle beats start on the beat after that.
- R7: A nonzero quanta that arrives during a running pause replaces the remaining time. From the next beat, Q×8 idle beats follow, and `idle_octet` restarts at 0.
- R8: A quanta of zero clears any held pause. `idle_force` is low on the next beat.
- R9: When a pause-frame request and a data request are both pending at a grant opportunity, only `pause_tx_grant` is raised. The two grants are never high together.
- R10: After a `frame_last` beat, no grant is issued on the next IPG_BEATS beats (default 2). A grant may be issued on the beat after those.
- R11: No grant is issued while a frame is in flight, that is, from the beat after a grant through the `frame_last` beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quanta_vld | input | 1 | One-beat strobe: a checked pause time is on `quanta` |
| quanta | input | 16 | Received pause time in 512-bit units |
| pause_tx_req | input | 1 | Level request to send a local pause frame |
| data_req | input | 1 | Level request to send a user data frame |
| frame_last | input | 1 | Last beat of the frame in flight |
| pause_tx_grant | output | 1 | Pause frame may start (combinational, one beat) |
| data_grant | output | 1 | Data frame may start (combinational, one beat) |
| idle_force | output | 1 | Lane is held at IDLE for a received pause |
| idle_octet | output | 22 | Octet offset of the current idle beat within the pause |
| idle_txd | output | 64 | IDLE data lane (0x07 per octet while forced) |
| idle_txc | output | 8 | IDLE control flags (all set while forced) |

## Verification
A table of quanta values (1, 2, 3, 7 and 0) is applied to a free line. The idle beats are counted and the first and last octet offsets are checked. Together these separate a correct ×8 beat scaling from off-by-one counts, and a zero value from a one-beat pulse. Directed sequences then raise both requests behind a held pause. They deliver a quanta during a frame, reload partway through a pause, and cancel with zero. These show whether priority, queuing until `frame_last`, restart of the octet count and cancellation each behave independently. A final sequence places a request right after a frame end to expose the length of the gap window.

// File: rtl/tx_pause_pkg.sv
package tx_pause_pkg;
  typedef enum logic [0:0] {
    LINE_FREE = 1'b0,
    LINE_BUSY = 1'b1
  } line_state_e;

  localparam logic [7:0] IDLE_CHAR   = 8'h07;
  localparam int         QUANTA_BITS = 512;
endpackage

// File: rtl/tps_quanta_ctr.sv
module tps_quanta_ctr #(
  parameter int QUANTA_W = 16,
  parameter int QSH      = 3,
  parameter int OSH      = 3,
  parameter int CNT_W    = QUANTA_W + QSH,
  parameter int OCT_W    = CNT_W + OSH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [QUANTA_W-1:0] value,
  input  logic                run,
  output logic                pending,
  output logic [OCT_W-1:0]    octet
);
  logic [CNT_W-1:0] left_q, left_d;
  logic [CNT_W-1:0] pos_q, pos_d;
  logic             en;

  always_comb begin
    left_d = left_q;
    pos_d  = pos_q;
    en     = 1'b0;
    if (load) begin
      left_d = CNT_W'(value) << QSH;
      pos_d  = '0;
      en     = 1'b1;
    end else if (run && (left_q != '0)) begin
      left_d = left_q - CNT_W'(1);
      pos_d  = pos_q + CNT_W'(1);
      en     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      pos_q  <= '0;
    end else if (en) begin
      left_q <= left_d;
      pos_q  <= pos_d;
    end
  end

  assign pending = (left_q != '0);
  assign octet   = OCT_W'(pos_q) << OSH;
endmodule

// File: rtl/tps_ipg_timer.sv
module tps_ipg_timer #(
  parameter int IPG_BEATS = 2,
  parameter int IPG_W     = (IPG_BEATS > 1) ? $clog2(IPG_BEATS + 1) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_done,
  output logic open
);
  generate
    if (IPG_BEATS == 0) begin : g_nogap
      assign open = 1'b1;
    end else begin : g_gap
      logic [IPG_W-1:0] cnt_q, cnt_d;
      logic             en;

      always_comb begin
        cnt_d = cnt_q;
        en    = 1'b0;
        if (frame_done) begin
          cnt_d = IPG_W'(IPG_BEATS);
          en    = 1'b1;
        end else if (cnt_q != '0) begin
          cnt_d = cnt_q - IPG_W'(1);
          en    = 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  cnt_q <= '0;
        else if (en) cnt_q <= cnt_d;
      end

      assign open = (cnt_q == '0);
    end
  endgenerate
endmodule

// File: rtl/tps_arbiter.sv
module tps_arbiter
  import tx_pause_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pause_held,
  input  logic gap_open,
  input  logic pause_tx_req,
  input  logic data_req,
  input  logic frame_last,
  output logic pause_tx_grant,
  output logic data_grant,
  output logic line_free,
  output logic frame_done
);
  line_state_e state_q, state_d;
  logic        may_start;

  assign line_free  = (state_q == LINE_FREE);
  assign frame_done = (state_q == LINE_BUSY) && frame_last;
  assign may_start  = line_free && !pause_held && gap_open;

  // The local pause frame ranks above data; a held received pause ranks above both.
  assign pause_tx_grant = may_start && pause_tx_req;
  assign data_grant     = may_start && data_req && !pause_tx_req;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LINE_FREE: if (pause_tx_grant || data_grant) state_d = LINE_BUSY;
      LINE_BUSY: if (frame_last)                   state_d = LINE_FREE;
      default:                                     state_d = LINE_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LINE_FREE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/tx_pause_sched.sv
module tx_pause_sched
  import tx_pause_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int QUANTA_W  = 16,
  parameter int IPG_BEATS = 2,
  localparam int BEAT_OCTETS = DATA_W / 8,
  localparam int BEATS_PER_Q = (QUANTA_BITS / 8) / BEAT_OCTETS,
  localparam int QSH         = $clog2(BEATS_PER_Q),
  localparam int OSH         = $clog2(BEAT_OCTETS),
  localparam int CNT_W       = QUANTA_W + QSH,
  localparam int OCT_W       = CNT_W + OSH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   quanta_vld,
  input  logic [QUANTA_W-1:0]    quanta,
  input  logic                   pause_tx_req,
  input  logic                   data_req,
  input  logic                   frame_last,
  output logic                   pause_tx_grant,
  output logic                   data_grant,
  output logic                   idle_force,
  output logic [OCT_W-1:0]       idle_octet,
  output logic [DATA_W-1:0]      idle_txd,
  output logic [BEAT_OCTETS-1:0] idle_txc
);
  logic             pause_held;
  logic             line_free;
  logic             frame_done;
  logic             gap_open;
  logic [OCT_W-1:0] octet_raw;

  tps_quanta_ctr #(
    .QUANTA_W (QUANTA_W),
    .QSH      (QSH),
    .OSH      (OSH),
    .CNT_W    (CNT_W),
    .OCT_W    (OCT_W)
  ) u_qctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (quanta_vld),
    .value   (quanta),
    .run     (line_free),
    .pending (pause_held),
    .octet   (octet_raw)
  );

  tps_ipg_timer #(
    .IPG_BEATS (IPG_BEATS)
  ) u_gap (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .open       (gap_open)
  );

  tps_arbiter u_arb (
    .clk            (clk),
    .rst_n          (rst_n),
    .pause_held     (pause_held),
    .gap_open       (gap_open),
    .pause_tx_req   (pause_tx_req),
    .data_req       (data_req),
    .frame_last     (frame_last),
    .pause_tx_grant (pause_tx_grant),
    .data_grant     (data_grant),
    .line_free      (line_free),
    .frame_done     (frame_done)
  );

  assign idle_force = line_free && pause_held;
  assign idle_octet = idle_force ? octet_raw : '0;

  generate
    for (genvar b = 0; b < BEAT_OCTETS; b++) begin : g_lane
      assign idle_txd[b*8 +: 8] = idle_force ? IDLE_CHAR : 8'h00;
      assign idle_txc[b]        = idle_force;
    end
  endgenerate
endmodule

// File: rtl/tx_pause_sched_chk.sv
module tx_pause_sched_chk #(
  parameter int DATA_W   = 64,
  parameter int QUANTA_W = 16,
  parameter int OCT_W    = 22
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  quanta_vld,
  input logic [QUANTA_W-1:0]   quanta,
  input logic                  pause_tx_grant,
  input logic                  data_grant,
  input logic                  frame_last,
  input logic                  idle_force,
  input logic [OCT_W-1:0]      idle_octet,
  input logic [DATA_W-1:0]     idle_txd,
  input logic [DATA_W/8-1:0]   idle_txc
);
  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            busy_q <= 1'b0;
    else if (pause_tx_grant || data_grant) busy_q <= 1'b1;
    else if (busy_q && frame_last)         busy_q <= 1'b0;
  end

  AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pause_tx_grant && data_grant)); // R9
  AST_NO_GRANT_IN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    idle_force |-> (!pause_tx_grant && !data_grant)); // R5
  AST_NO_GRANT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (!pause_tx_grant && !data_grant)); // R11
  AST_IDLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    idle_force |-> (idle_txd == {(DATA_W/8){8'h07}}) && (&idle_txc)); // R3
  AST_QUIET_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_force |-> (idle_txd == '0) && (idle_txc == '0)); // R3
  AST_OCTET_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_force) |-> (idle_octet == '0)); // R4
  AST_OCTET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_force && $past(idle_force) && !$past(quanta_vld))
      |-> (idle_octet == OCT_W'($past(idle_octet) + OCT_W'(DATA_W/8)))); // R4
  AST_QUEUED_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !idle_force); // R6
  AST_PAUSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !pause_tx_grant && !data_grant && quanta_vld && (quanta != '0))
      |=> idle_force); // R2
  AST_ZERO_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (quanta_vld && (quanta == '0)) |=> !idle_force); // R8
endmodule

bind tx_pause_sched tx_pause_sched_chk #(
  .DATA_W   (DATA_W),
  .QUANTA_W (QUANTA_W),
  .OCT_W    (OCT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .quanta_vld     (quanta_vld),
  .quanta         (quanta),
  .pause_tx_grant (pause_tx_grant),
  .data_grant     (data_grant),
  .frame_last     (frame_last),
  .idle_force     (idle_force),
  .idle_octet     (idle_octet),
  .idle_txd       (idle_txd),
  .idle_txc       (idle_txc)
);

// File: tb/tx_pause_sched_tb.sv
module tx_pause_sched_tb;
  localparam int DATA_W = 64;
  localparam int QW     = 16;
  localparam int OW     = 22;
  localparam int NVEC   = 5;
  // each row: quanta value, expected idle beats
  localparam int VEC [NVEC][2] = '{'{1, 8}, '{3, 24}, '{2, 16}, '{0, 0}, '{7, 56}};
  localparam logic [DATA_W-1:0] IDLE_WORD = {(DATA_W/8){8'h07}};

  logic clk = 1'b0;
  logic rst_n;
  logic quanta_vld;
  logic [QW-1:0] quanta;
  logic pause_tx_req, data_req, frame_last;
  logic pause_tx_grant, data_grant, idle_force;
  logic [OW-1:0] idle_octet;
  logic [DATA_W-1:0] idle_txd;
  logic [DATA_W/8-1:0] idle_txc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tx_pause_sched u_dut (
    .clk(clk), .rst_n(rst_n), .quanta_vld(quanta_vld), .quanta(quanta),
    .pause_tx_req(pause_tx_req), .data_req(data_req), .frame_last(frame_last),
    .pause_tx_grant(pause_tx_grant), .data_grant(data_grant),
    .idle_force(idle_force), .idle_octet(idle_octet),
    .idle_txd(idle_txd), .idle_txc(idle_txc)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic beat();
    @(negedge clk);
    #1;
  endtask

  // counts idle beats from the current sample point; checks grants stay low
  task automatic count_idle(output int n, output longint last_oct);
    n = 0;
    last_oct = 0;
    while (idle_force && n < 5000) begin
      chk(!pause_tx_grant && !data_grant, "R5", pause_tx_grant | data_grant, 0);
      last_oct = idle_octet;
      n++;
      beat();
    end
  endtask

  initial begin
    int n;
    longint lo;
    rst_n = 1'b0; quanta_vld = 1'b0; quanta = '0;
    pause_tx_req = 1'b0; data_req = 1'b0; frame_last = 1'b0;
    repeat (3) beat();
    // R1 reset state
    chk(!pause_tx_grant && !data_grant && !idle_force && idle_octet == 0 &&
        idle_txd == 0 && idle_txc == 0, "R1", idle_force, 0);
    @(negedge clk); rst_n = 1'b1; #1;
    chk(!pause_tx_grant && !data_grant && !idle_force && idle_txd == 0, "R1", idle_force, 0);

    // table walk: pause lengths on a free line (R2, R3, R4)
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk); quanta_vld = 1'b1; quanta = QW'(VEC[i][0]);
      @(negedge clk); quanta_vld = 1'b0; #1;
      if (VEC[i][1] > 0) begin
        chk(idle_octet == 0, "R4", idle_octet, 0);
        chk(idle_txd == IDLE_WORD && idle_txc == '1, "R3", idle_txd, IDLE_WORD);
      end
      count_idle(n, lo);
      chk(n == VEC[i][1], "R2", n, VEC[i][1]);
      if (VEC[i][1] > 0) chk(lo == (VEC[i][1] - 1) * 8, "R4", lo, (VEC[i][1] - 1) * 8);
      chk(idle_txd == 0 && idle_txc == 0, "R3", idle_txd, 0);
      repeat (2) beat();
    end

    // R5 / R9: both requests behind a held pause
    @(negedge clk); quanta_vld = 1'b1; quanta = 16'd1;
    @(negedge clk); quanta_vld = 1'b0; pause_tx_req = 1'b1; data_req = 1'b1; #1;
    count_idle(n, lo);
    chk(n == 8, "R5", n, 8);
    chk(pause_tx_grant && !data_grant, "R9", {pause_tx_grant, data_grant}, 2);
    @(negedge clk); pause_tx_req = 1'b0; #1;
    // R11 frame in flight
    chk(!pause_tx_grant && !data_grant, "R11", data_grant, 0);
    // R6 quanta during frame is queued
    @(negedge clk); quanta_vld = 1'b1; quanta = 16'd2; #1;
    chk(!idle_force, "R6", idle_force, 0);
    @(negedge clk); quanta_vld = 1'b0; #1;
    chk(!idle_force && !data_grant, "R6", idle_force, 0);
    @(negedge clk); frame_last = 1'b1; #1;
    chk(!idle_force && !data_grant, "R6", idle_force, 0);
    @(negedge clk); frame_last = 1'b0; #1;
    chk(idle_force && idle_octet == 0, "R6", idle_force, 1);
    count_idle(n, lo);
    chk(n == 16, "R6", n, 16);
    chk(data_grant && !pause_tx_grant, "R5", data_grant, 1);

    // R10 gap after frame end
    @(negedge clk); #1;
    chk(!data_grant, "R11", data_grant, 0);
    @(negedge clk); frame_last = 1'b1; #1;
    chk(!data_grant, "R11", data_grant, 0);
    @(negedge clk); frame_last = 1'b0; #1;
    chk(!data_grant, "R10", data_grant, 0);
    beat();
    chk(!data_grant, "R10", data_grant, 0);
    beat();
    chk(data_grant, "R10", data_grant, 1);
    @(negedge clk); data_req = 1'b0;
    @(negedge clk); frame_last = 1'b1;
    @(negedge clk); frame_last = 1'b0;
    repeat (4) beat();

    // R7 overwrite during a running pause
    @(negedge clk); quanta_vld = 1'b1; quanta = 16'd4;
    @(negedge clk); quanta_vld = 1'b0;
    repeat (5) beat();
    chk(idle_octet == 40, "R4", idle_octet, 40);
    @(negedge clk); quanta_vld = 1'b1; quanta = 16'd1;
    @(negedge clk); quanta_vld = 1'b0; #1;
    chk(idle_force && idle_octet == 0, "R7", idle_octet, 0);
    count_idle(n, lo);
    chk(n == 8, "R7", n, 8);
    repeat (2) beat();

    // R8 zero cancels a running pause
    @(negedge clk); quanta_vld = 1'b1; quanta = 16'd3;
    @(negedge clk); quanta_vld = 1'b0;
    beat();
    chk(idle_force, "R8", idle_force, 1);
    @(negedge clk); quanta_vld = 1'b1; quanta = 16'd0;
    @(negedge clk); quanta_vld = 1'b0; #1;
    chk(!idle_force, "R8", idle_force, 0);
    chk(idle_txd == 0, "R3", idle_txd, 0);
    repeat (3) beat();
    chk(!idle_force, "R8", idle_force, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule